// File: doc/BRIEF.md
# Flag-Driven Floating-Point Select Unit

This block decodes and carries out a floating-point conditional select. A 32-bit instruction word is presented with a valid strobe, together with the four condition flags (negative, zero, carry, overflow), an enable for half-precision operation and an indication that the word sits inside a conditional-execution block. When the word carries the select opcode, the unit extracts a 2-bit condition selector, a 2-bit element size and three register indices. It tests the selected condition against the flags, then copies either the first or the second source operand into the destination register of an internal file of 32 registers of 64 bits.

Encodings that are reserved, that need half precision while it is disabled, or that appear inside a conditional-execution block produce no register write. Each raises its own one-cycle status pulse, as does any word that does not carry the opcode. A combinational read port shows any 64-bit register, which lets the surrounding pipeline, or a bench, see the file contents.

Top module: `fpsel_unit`

## Requirements
- R1: A word is recognised only when bits 31..23 equal 111111100, bits 11..10 equal 10, bit 6 is 0 and bit 4 is 0. Any other valid word writes no register and pulses `nomatch_o`.
- R2: Size field bits 9..8 = 00 is undefined. Size 01 (half precision) is undefined while `half_en` is low. Either case pulses `undef_o` and writes nothing.
- R3: A recognised word presented with `in_cond_block` high pulses `unpred_o` and writes nothing. This takes precedence over R2.
- R4: The condition selector in bits 21..20 chooses the test: 00 holds when Z=1, 01 holds when V=1, 10 holds when N=V, and 11 holds when Z=0 and N=V.
- R5: When the condition holds, the destination receives the first source (fields bit 7 and bits 19..16). Otherwise it receives the second source (fields bit 5 and bits 3..0).
- R6: For size 11 each 5-bit index puts the single bit on top: destination {bit22, bits15..12}, first source {bit7, bits19..16} and second source {bit5, bits3..0}. The whole 64-bit register is written.
- R7: For sizes 01 and 10 each index puts the single bit at the bottom ({bits15..12, bit22} and so on). 32-bit register k is bits 63..32 of 64-bit register k/2 when k is odd, and bits 31..0 when k is even. The other half stays unchanged.
- R8: For size 01 the low 16 bits of the chosen 32-bit source are written to the low 16 bits of the destination 32-bit register, and its upper 16 bits are cleared.
- R9: A write shows on `dbg_data` after the rising edge that samples the valid word. Status pulses last exactly one cycle. A cycle with `instr_valid` low changes nothing.
- R10: After reset, 64-bit register k holds {8'h5A, k, 8'h80, k, 8'hA5, k, 8'h00, k XOR 31}, with each k field 8 bits wide. All status outputs are low.
- R11: At most one status output is high in any cycle, and none is high in the cycle after a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| half_en | input | 1 | Half-precision operation enabled |
| in_cond_block | input | 1 | Word lies inside a conditional-execution block |
| dbg_idx | input | 5 | 64-bit register index to show |
| dbg_data | output | 64 | Contents of register `dbg_idx` |
| undef_o | output | 1 | One-cycle pulse: undefined encoding |
| unpred_o | output | 1 | One-cycle pulse: unpredictable placement |
| nomatch_o | output | 1 | One-cycle pulse: word is not a select |

## Verification
Two faults can hit the same word: a reserved or disabled size and placement inside a conditional-execution block. The sweep crosses every size code with both `half_en` values and both `in_cond_block` values, so every combination of the two faults occurs. In each case only `unpred_o` may pulse and the target register must read back unchanged. The bench also checks that a legal write and a status pulse never occur together, by reading the destination back after every vector.

// File: rtl/fpsel_pkg.sv
package fpsel_pkg;

    localparam int unsigned NUM_DREGS = 32;
    localparam int unsigned DREG_W    = 64;
    localparam int unsigned IDX_W     = $clog2(NUM_DREGS);
    localparam int unsigned SREG_W    = DREG_W / 2;
    localparam int unsigned HREG_W    = SREG_W / 2;

    typedef enum logic [1:0] {
        SZ_RSVD   = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_SINGLE = 2'b10,
        SZ_DOUBLE = 2'b11
    } elem_size_e;

    typedef struct packed {
        logic             match;
        logic [1:0]       sel;
        elem_size_e       size;
        logic [IDX_W-1:0] idx_d;
        logic [IDX_W-1:0] idx_n;
        logic [IDX_W-1:0] idx_m;
        logic [3:0]       cond;
    } sel_decode_t;

    typedef struct packed {
        logic undef;
        logic unpred;
        logic nomatch;
    } sel_status_t;

    // Reset content of 64-bit register k (each k field zero-extended to 8 bits)
    function automatic logic [63:0] reset_pattern(input logic [4:0] k);
        return {8'h5A, 3'b000, k, 8'h80, 3'b000, k,
                8'hA5, 3'b000, k, 8'h00, 3'b000, k ^ 5'h1F};
    endfunction

endpackage

// File: rtl/fpsel_decode.sv
module fpsel_decode
    import fpsel_pkg::*;
(
    input  logic [31:0]  word,
    output sel_decode_t  dec
);
    logic bit_d, bit_n, bit_m;
    logic [3:0] fld_d, fld_n, fld_m;

    always_comb begin
        bit_d = word[22];
        bit_n = word[7];
        bit_m = word[5];
        fld_d = word[15:12];
        fld_n = word[19:16];
        fld_m = word[3:0];

        dec.match = (word[31:23] == 9'b111111100) && (word[11:10] == 2'b10)
                    && !word[6] && !word[4];
        dec.sel   = word[21:20];
        dec.size  = elem_size_e'(word[9:8]);

        if (dec.size == SZ_DOUBLE) begin
            dec.idx_d = {bit_d, fld_d};
            dec.idx_n = {bit_n, fld_n};
            dec.idx_m = {bit_m, fld_m};
        end else begin
            dec.idx_d = {fld_d, bit_d};
            dec.idx_n = {fld_n, bit_n};
            dec.idx_m = {fld_m, bit_m};
        end

        // 4-bit condition: selector, xor of its bits, then a zero
        dec.cond = {dec.sel, dec.sel[1] ^ dec.sel[0], 1'b0};
    end
endmodule

// File: rtl/fpsel_cond.sv
module fpsel_cond (
    input  logic [3:0] cond,
    input  logic       fn,
    input  logic       fz,
    input  logic       fc,
    input  logic       fv,
    output logic       holds
);
    logic base;

    always_comb begin
        unique case (cond[3:1])
            3'b000:  base = fz;
            3'b001:  base = fc;
            3'b010:  base = fn;
            3'b011:  base = fv;
            3'b100:  base = fc && !fz;
            3'b101:  base = (fn == fv);
            3'b110:  base = (fn == fv) && !fz;
            default: base = 1'b1;
        endcase
        holds = (cond[0] && (cond[3:1] != 3'b111)) ? !base : base;
    end
endmodule

// File: rtl/fpsel_regfile.sv
module fpsel_regfile
    import fpsel_pkg::*;
#(
    parameter int unsigned NREGS  = NUM_DREGS,
    parameter int unsigned WIDTH  = DREG_W,
    parameter int unsigned RPORTS = 3,
    localparam int unsigned AW    = $clog2(NREGS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_idx,
    input  logic [WIDTH-1:0]             wr_data,
    input  logic [WIDTH-1:0]             wr_mask,
    input  logic [RPORTS-1:0][AW-1:0]    rd_idx,
    output logic [RPORTS-1:0][WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem_d [NREGS];
    logic [WIDTH-1:0] mem_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_idx] = (mem_q[wr_idx] & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                mem_q[i] <= WIDTH'(reset_pattern(5'(i)));
            end
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    for (genvar p = 0; p < RPORTS; p++) begin : g_rport
        assign rd_data[p] = mem_q[rd_idx[p]];
    end
endmodule

// File: rtl/fpsel_unit.sv
module fpsel_unit
    import fpsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        instr_valid,
    input  logic [31:0] instr_word,
    input  logic        flag_n,
    input  logic        flag_z,
    input  logic        flag_c,
    input  logic        flag_v,
    input  logic        half_en,
    input  logic        in_cond_block,
    input  logic [4:0]  dbg_idx,
    output logic [63:0] dbg_data,
    output logic        undef_o,
    output logic        unpred_o,
    output logic        nomatch_o
);
    localparam int unsigned RP_N   = 0;
    localparam int unsigned RP_M   = 1;
    localparam int unsigned RP_DBG = 2;

    sel_decode_t dec;
    logic        cond_ok;
    logic        size_bad;
    logic        legal;

    logic                      rf_wr_en;
    logic [IDX_W-1:0]          rf_wr_idx;
    logic [DREG_W-1:0]         rf_wr_data;
    logic [DREG_W-1:0]         rf_wr_mask;
    logic [2:0][IDX_W-1:0]     rf_rd_idx;
    logic [2:0][DREG_W-1:0]    rf_rd_data;

    logic [DREG_W-1:0]         opnd_n;
    logic [DREG_W-1:0]         opnd_m;
    logic [DREG_W-1:0]         chosen;
    logic [SREG_W-1:0]         narrow;

    sel_status_t st_d, st_q;

    fpsel_decode u_decode (
        .word (instr_word),
        .dec  (dec)
    );

    fpsel_cond u_cond (
        .cond  (dec.cond),
        .fn    (flag_n),
        .fz    (flag_z),
        .fc    (flag_c),
        .fv    (flag_v),
        .holds (cond_ok)
    );

    // Pick an operand view out of a 64-bit register according to element size
    function automatic logic [DREG_W-1:0] view_operand(
        input elem_size_e       sz,
        input logic [IDX_W-1:0] idx,
        input logic [DREG_W-1:0] raw
    );
        logic [SREG_W-1:0] word32;
        word32 = idx[0] ? raw[DREG_W-1:SREG_W] : raw[SREG_W-1:0];
        case (sz)
            SZ_DOUBLE: return raw;
            SZ_HALF:   return {{(DREG_W-HREG_W){1'b0}}, word32[HREG_W-1:0]};
            default:   return {{(DREG_W-SREG_W){1'b0}}, word32};
        endcase
    endfunction

    always_comb begin
        rf_rd_idx[RP_DBG] = dbg_idx;
        if (dec.size == SZ_DOUBLE) begin
            rf_rd_idx[RP_N] = dec.idx_n;
            rf_rd_idx[RP_M] = dec.idx_m;
        end else begin
            rf_rd_idx[RP_N] = dec.idx_n >> 1;
            rf_rd_idx[RP_M] = dec.idx_m >> 1;
        end
    end

    assign dbg_data = rf_rd_data[RP_DBG];

    always_comb begin
        opnd_n = view_operand(dec.size, dec.idx_n, rf_rd_data[RP_N]);
        opnd_m = view_operand(dec.size, dec.idx_m, rf_rd_data[RP_M]);
        chosen = cond_ok ? opnd_n : opnd_m;
        narrow = chosen[SREG_W-1:0];

        size_bad = (dec.size == SZ_RSVD) || ((dec.size == SZ_HALF) && !half_en);
        legal    = dec.match && !in_cond_block && !size_bad;

        rf_wr_en = instr_valid && legal;
        if (dec.size == SZ_DOUBLE) begin
            rf_wr_idx  = dec.idx_d;
            rf_wr_data = chosen;
            rf_wr_mask = '1;
        end else begin
            rf_wr_idx  = dec.idx_d >> 1;
            rf_wr_data = {narrow, narrow};
            rf_wr_mask = dec.idx_d[0] ? {{SREG_W{1'b1}}, {SREG_W{1'b0}}}
                                      : {{SREG_W{1'b0}}, {SREG_W{1'b1}}};
        end
    end

    fpsel_regfile #(
        .NREGS  (NUM_DREGS),
        .WIDTH  (DREG_W),
        .RPORTS (3)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rf_wr_en),
        .wr_idx  (rf_wr_idx),
        .wr_data (rf_wr_data),
        .wr_mask (rf_wr_mask),
        .rd_idx  (rf_rd_idx),
        .rd_data (rf_rd_data)
    );

    // Status pulses: non-match, then misplacement, then bad size
    always_comb begin
        st_d = '0;
        if (instr_valid) begin
            st_d.nomatch = !dec.match;
            st_d.unpred  = dec.match && in_cond_block;
            st_d.undef   = dec.match && !in_cond_block && size_bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign undef_o   = st_q.undef;
    assign unpred_o  = st_q.unpred;
    assign nomatch_o = st_q.nomatch;
endmodule

// File: rtl/fpsel_unit_chk.sv
module fpsel_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid,
    input logic [31:0] word,
    input logic        half_en,
    input logic        in_it,
    input logic        wr_en,
    input logic        undef,
    input logic        unpred,
    input logic        nomatch
);
    logic opcode_ok;
    assign opcode_ok = (word[31:23] == 9'b111111100) && (word[11:10] == 2'b10)
                       && (word[6] == 1'b0) && (word[4] == 1'b0);

    assert_status_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({undef, unpred, nomatch}));

    assert_write_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !(undef || unpred || nomatch));

    assert_nomatch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !opcode_ok) |=> nomatch);

    assert_unpred_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && opcode_ok && in_it) |=> (unpred && !undef));

    assert_half_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && opcode_ok && !in_it && word[9:8] == 2'b01 && !half_en) |=> undef);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> !(undef || unpred || nomatch));

    assert_no_write_on_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (!opcode_ok || in_it)) |-> !wr_en);
endmodule

bind fpsel_unit fpsel_unit_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (instr_valid),
    .word    (instr_word),
    .half_en (half_en),
    .in_it   (in_cond_block),
    .wr_en   (rf_wr_en),
    .undef   (undef_o),
    .unpred  (unpred_o),
    .nomatch (nomatch_o)
);

// File: tb/fpsel_unit_tb_top.sv
module fpsel_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
    logic        half_en = 1'b0;
    logic        in_cond_block = 1'b0;
    logic [4:0]  dbg_idx = '0;
    logic [63:0] dbg_data;
    logic        undef_o, unpred_o, nomatch_o;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5678;
    logic [63:0] model [32];

    always #10 clk = ~clk;

    fpsel_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .half_en(half_en), .in_cond_block(in_cond_block), .dbg_idx(dbg_idx),
        .dbg_data(dbg_data), .undef_o(undef_o), .unpred_o(unpred_o), .nomatch_o(nomatch_o)
    );

    function automatic logic [63:0] init_val(input int k);
        logic [7:0] kb;
        kb = 8'(k);
        return {8'h5A, kb, 8'h80, kb, 8'hA5, kb, 8'h00, kb ^ 8'h1F};
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] operand(input logic [1:0] sz, input logic [4:0] idx);
        logic [31:0] w;
        if (sz == 2'b11) return model[idx];
        w = idx[0] ? model[idx >> 1][63:32] : model[idx >> 1][31:0];
        if (sz == 2'b01) return {48'b0, w[15:0]};
        return {32'b0, w};
    endfunction

    // One instruction: drive, let it be sampled, check status pulse and target register
    task automatic apply(input logic [31:0] w, input logic [3:0] fl,
                         input logic he, input logic it, input bit idle_chk);
        logic [1:0] sz, cc;
        logic [4:0] d5, n5, m5, tgt;
        logic opc, bad_sz, cond, wr;
        logic [2:0] exp_st;
        logic [63:0] src;
        logic [31:0] v32;
        sz  = w[9:8];
        cc  = w[21:20];
        opc = (w[31:23] == 9'b111111100) && (w[11:10] == 2'b10) && !w[6] && !w[4];
        if (sz == 2'b11) begin
            d5 = {w[22], w[15:12]}; n5 = {w[7], w[19:16]}; m5 = {w[5], w[3:0]};
            tgt = d5;
        end else begin
            d5 = {w[15:12], w[22]}; n5 = {w[19:16], w[7]}; m5 = {w[3:0], w[5]};
            tgt = d5 >> 1;
        end
        bad_sz = (sz == 2'b00) || (sz == 2'b01 && !he);
        case (cc)   // fl = {N, Z, C, V}
            2'b00: cond = fl[2];
            2'b01: cond = fl[0];
            2'b10: cond = (fl[3] == fl[0]);
            default: cond = !fl[2] && (fl[3] == fl[0]);
        endcase
        // {undef, unpred, nomatch}
        if (!opc)          exp_st = 3'b001;
        else if (it)       exp_st = 3'b010;
        else if (bad_sz)   exp_st = 3'b100;
        else               exp_st = 3'b000;
        wr = opc && !it && !bad_sz;
        if (wr) begin
            src = cond ? operand(sz, n5) : operand(sz, m5);
            if (sz == 2'b11) model[tgt] = src;
            else begin
                v32 = src[31:0];
                if (d5[0]) model[tgt][63:32] = v32;
                else       model[tgt][31:0]  = v32;
            end
        end

        @(negedge clk);
        instr_word = w; instr_valid = 1'b1;
        {flag_n, flag_z, flag_c, flag_v} = fl;
        half_en = he; in_cond_block = it;
        @(negedge clk);
        instr_valid = 1'b0;
        dbg_idx = tgt;
        #1;
        if (!opc)       check("R1 status", {61'b0, undef_o, unpred_o, nomatch_o}, {61'b0, exp_st});
        else if (it)    check("R3 status", {61'b0, undef_o, unpred_o, nomatch_o}, {61'b0, exp_st});
        else if (bad_sz) check("R2 status", {61'b0, undef_o, unpred_o, nomatch_o}, {61'b0, exp_st});
        else            check("R11 status", {61'b0, undef_o, unpred_o, nomatch_o}, {61'b0, exp_st});
        if (!wr)               check("R1 R2 R3 no write", dbg_data, model[tgt]);
        else if (sz == 2'b11)  check("R4 R5 R6 double", dbg_data, model[tgt]);
        else if (sz == 2'b01)  check("R4 R5 R7 R8 half", dbg_data, model[tgt]);
        else                   check("R4 R5 R7 single", dbg_data, model[tgt]);
        if (idle_chk) begin
            @(negedge clk);
            #1;
            check("R9 pulse width", {61'b0, undef_o, unpred_o, nomatch_o}, 64'd0);
            check("R9 idle no change", dbg_data, model[tgt]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 32; k++) model[k] = init_val(k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 status at reset", {61'b0, undef_o, unpred_o, nomatch_o}, 64'd0);
        for (int k = 0; k < 32; k++) begin
            dbg_idx = 5'(k);
            #1;
            check("R10 reset content", dbg_data, model[k]);
        end

        // Full sweep of selector, size, flags, half enable and block placement
        for (int cc = 0; cc < 4; cc++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int fl = 0; fl < 16; fl++) begin
                    for (int he = 0; he < 2; he++) begin
                        for (int it = 0; it < 2; it++) begin
                            logic [31:0] w;
                            seed = next_rand(seed);
                            w = {9'b111111100, seed[22], 2'(cc), seed[19:12],
                                 2'b10, 2'(sz), seed[7], 1'b0, seed[5], 1'b0, seed[3:0]};
                            apply(w, 4'(fl), 1'(he), 1'(it), (fl == 0));
                        end
                    end
                end
            end
        end

        // Corrupt each fixed opcode bit in turn
        for (int b = 0; b < 32; b++) begin
            logic [31:0] w;
            if (!((b >= 23) || b == 11 || b == 10 || b == 6 || b == 4)) continue;
            seed = next_rand(seed);
            w = {9'b111111100, seed[22:12], 2'b10, 2'b11, seed[7], 1'b0, seed[5], 1'b0, seed[3:0]};
            w[b] = ~w[b];
            apply(w, seed[27:24], 1'b1, 1'b0, 1'b1);
        end

        // Final content sweep
        for (int k = 0; k < 32; k++) begin
            dbg_idx = 5'(k);
            #1;
            check("R7 final content", dbg_data, model[k]);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule